// File: doc/BRIEF.md
# Three-Stage Integer Pipeline with Result Bypass

This block is a small register-to-register execution pipeline. One instruction may enter per clock through a flat instruction port that carries an operation code, a destination register, two source registers and an immediate word. Stage I latches the instruction. Stage A reads both sources from the register file, picks each operand and computes the result. That result goes into a one-entry result buffer, and stage E writes the buffer into the register file at the end of its cycle.

A dependent instruction that follows its producer directly finds the producer in stage E, before the register file has been updated. A forwarding multiplexer on each ALU input then takes the result buffer in place of the register-file output, so the pipeline never stalls. An instruction two or more slots behind its producer reads the register file, which the producer has already written by then. A combinational debug port shows the committed register contents. A write-back observation port shows each register write while it is in stage E.

Top module: `bypass_pipe3`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, every register reads zero on the debug port and `wb_valid` is low.
- R2: Operation code 1 writes `rs1 + rs2` (modulo 2^16) to `rd`. An instruction sampled at clock edge k shows on the write-back port (`wb_valid`, `wb_addr`, `wb_data`) after edge k+2, is not yet visible after edge k+1, and is readable on the debug port after edge k+3.
- R3: Operation code 2 writes `rs1 - rs2` (modulo 2^16) to `rd`.
- R4: Operation code 3 writes the `in_imm` word to `rd`. It is the only way to load an operand value.
- R5: Operation code 0, codes 4 to 7, and any cycle with `in_valid` low produce no write-back and change no register.
- R6: Register 0 always reads zero. An instruction whose destination is register 0 produces no write-back, and it is never forwarded to a later instruction.
- R7: An instruction that reads the destination of the instruction directly ahead of it gets the new value with no stall cycle, on either operand or on both.
- R8: An instruction two slots behind its producer, whether the slot between holds an instruction, a bubble or a non-writing code, gets the producer's value from the register file.
- R9: Forwarding happens only when the instruction in stage E writes a register. A source that matches the destination field of a non-writing instruction in stage E reads the register file.
- R10: For any sequence issued one per cycle, the register contents once the pipeline has drained equal those of in-order, one-at-a-time execution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction present this cycle |
| in_op | input | 3 | Operation code: 0 none, 1 add, 2 subtract, 3 load immediate, 4-7 none |
| in_rd | input | 3 | Destination register |
| in_rs1 | input | 3 | First source register |
| in_rs2 | input | 3 | Second source register |
| in_imm | input | 16 | Immediate word for operation code 3 |
| dbg_addr | input | 3 | Debug read register index |
| dbg_data | output | 16 | Committed contents of register `dbg_addr` |
| wb_valid | output | 1 | A register write is in stage E |
| wb_addr | output | 3 | Register being written |
| wb_data | output | 16 | Value being written |

## Verification
The checker watches write-back timing and enable on every cycle. It confirms that only writing codes with a nonzero destination reach stage E, exactly two edges after they enter. It also confirms that nothing addressed to register 0 is ever written back and that the outputs are quiet straight after reset, and it checks that a written value appears on the debug port at the next edge. Forwarding cannot be judged from the ports on one cycle alone: its correctness shows only in the register values. The directed scenarios therefore run back-to-back dependent chains, dependencies with a gap of two, bubbles and non-writing codes between producer and consumer, and writes to register 0. They then compare every register against an in-order model.

// File: rtl/bp3_pkg.sv
package bp3_pkg;

    // Operation codes on the 3-bit instruction field
    localparam logic [2:0] OPC_NONE = 3'd0;
    localparam logic [2:0] OPC_ADD  = 3'd1;
    localparam logic [2:0] OPC_SUB  = 3'd2;
    localparam logic [2:0] OPC_LDI  = 3'd3;

    typedef enum logic [1:0] {
        ALU_PASS_ZERO = 2'd0,
        ALU_SUM       = 2'd1,
        ALU_DIFF      = 2'd2,
        ALU_IMM       = 2'd3
    } alu_sel_e;

    // True when the code produces a register result
    function automatic logic op_writes(input logic [2:0] op);
        return (op == OPC_ADD) || (op == OPC_SUB) || (op == OPC_LDI);
    endfunction

    function automatic alu_sel_e op_to_alu(input logic [2:0] op);
        alu_sel_e sel;
        case (op)
            OPC_ADD: sel = ALU_SUM;
            OPC_SUB: sel = ALU_DIFF;
            OPC_LDI: sel = ALU_IMM;
            default: sel = ALU_PASS_ZERO;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/bp3_fetch.sv
// Stage I: latches one instruction per clock
module bp3_fetch #(
    parameter int DW = 16,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [2:0]    in_op,
    input  logic [AW-1:0] in_rd,
    input  logic [AW-1:0] in_rs1,
    input  logic [AW-1:0] in_rs2,
    input  logic [DW-1:0] in_imm,
    output logic          fi_valid,
    output logic [2:0]    fi_op,
    output logic [AW-1:0] fi_rd,
    output logic [AW-1:0] fi_rs1,
    output logic [AW-1:0] fi_rs2,
    output logic [DW-1:0] fi_imm
);

    typedef struct packed {
        logic          valid;
        logic [2:0]    op;
        logic [AW-1:0] rd;
        logic [AW-1:0] rs1;
        logic [AW-1:0] rs2;
        logic [DW-1:0] imm;
    } fetch_t;

    fetch_t fetch_d, fetch_q;

    always_comb begin
        fetch_d       = fetch_q;
        fetch_d.valid = in_valid;
        if (in_valid) begin
            fetch_d.op  = in_op;
            fetch_d.rd  = in_rd;
            fetch_d.rs1 = in_rs1;
            fetch_d.rs2 = in_rs2;
            fetch_d.imm = in_imm;
        end else begin
            fetch_d.op  = bp3_pkg::OPC_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_q <= '0;
        end else begin
            fetch_q <= fetch_d;
        end
    end

    assign fi_valid = fetch_q.valid;
    assign fi_op    = fetch_q.op;
    assign fi_rd    = fetch_q.rd;
    assign fi_rs1   = fetch_q.rs1;
    assign fi_rs2   = fetch_q.rs2;
    assign fi_imm   = fetch_q.imm;

endmodule

// File: rtl/bp3_regfile.sv
// Architectural registers; index 0 is hard zero
module bp3_regfile #(
    parameter int DW   = 16,
    parameter int NREG = 8,
    parameter int AW   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    input  logic [AW-1:0] ra_dbg,
    output logic [DW-1:0] rd_a,
    output logic [DW-1:0] rd_b,
    output logic [DW-1:0] rd_dbg
);

    logic [DW-1:0] regs_d [NREG];
    logic [DW-1:0] regs_q [NREG];

    always_comb begin
        regs_d[0] = '0;
        for (int i = 1; i < NREG; i++) begin
            regs_d[i] = regs_q[i];
            if (wr_en && (wr_addr == AW'(i))) begin
                regs_d[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd_a   = regs_q[ra_a];
    assign rd_b   = regs_q[ra_b];
    assign rd_dbg = regs_q[ra_dbg];

endmodule

// File: rtl/bp3_fwd_mux.sv
// Operand select: result buffer when stage E writes the source register
module bp3_fwd_mux #(
    parameter int DW = 16,
    parameter int AW = 3
) (
    input  logic [AW-1:0] src,
    input  logic [DW-1:0] rf_val,
    input  logic          ex_wr,
    input  logic [AW-1:0] ex_rd,
    input  logic [DW-1:0] ex_val,
    output logic [DW-1:0] operand
);

    logic hit;

    always_comb begin
        hit     = ex_wr && (ex_rd != '0) && (ex_rd == src);
        operand = hit ? ex_val : rf_val;
    end

endmodule

// File: rtl/bp3_exec.sv
// Stage A: operand bypass, ALU, and the result buffer feeding stage E
module bp3_exec #(
    parameter int DW = 16,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fi_valid,
    input  logic [2:0]    fi_op,
    input  logic [AW-1:0] fi_rd,
    input  logic [AW-1:0] fi_rs1,
    input  logic [AW-1:0] fi_rs2,
    input  logic [DW-1:0] fi_imm,
    input  logic [DW-1:0] rf_a,
    input  logic [DW-1:0] rf_b,
    output logic          ex_wr,
    output logic [AW-1:0] ex_rd,
    output logic [DW-1:0] ex_val
);

    import bp3_pkg::*;

    localparam int NSRC = 2;

    typedef struct packed {
        logic          wr;
        logic [AW-1:0] rd;
        logic [DW-1:0] val;
    } resbuf_t;

    resbuf_t resbuf_d, resbuf_q;

    logic [AW-1:0] src_idx [NSRC];
    logic [DW-1:0] src_rf  [NSRC];
    logic [DW-1:0] src_opd [NSRC];

    assign src_idx[0] = fi_rs1;
    assign src_idx[1] = fi_rs2;
    assign src_rf[0]  = rf_a;
    assign src_rf[1]  = rf_b;

    for (genvar g = 0; g < NSRC; g++) begin : g_opd
        bp3_fwd_mux #(
            .DW(DW),
            .AW(AW)
        ) u_fwd (
            .src    (src_idx[g]),
            .rf_val (src_rf[g]),
            .ex_wr  (resbuf_q.wr),
            .ex_rd  (resbuf_q.rd),
            .ex_val (resbuf_q.val),
            .operand(src_opd[g])
        );
    end

    alu_sel_e      alu_sel;
    logic [DW-1:0] alu_out;

    always_comb begin
        alu_sel = op_to_alu(fi_op);
        case (alu_sel)
            ALU_SUM:  alu_out = src_opd[0] + src_opd[1];
            ALU_DIFF: alu_out = src_opd[0] - src_opd[1];
            ALU_IMM:  alu_out = fi_imm;
            default:  alu_out = '0;
        endcase

        resbuf_d     = resbuf_q;
        resbuf_d.wr  = fi_valid && op_writes(fi_op) && (fi_rd != '0);
        resbuf_d.rd  = fi_rd;
        resbuf_d.val = alu_out;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resbuf_q <= '0;
        end else begin
            resbuf_q <= resbuf_d;
        end
    end

    assign ex_wr  = resbuf_q.wr;
    assign ex_rd  = resbuf_q.rd;
    assign ex_val = resbuf_q.val;

endmodule

// File: rtl/bypass_pipe3.sv
module bypass_pipe3 #(
    parameter  int DW   = 16,
    parameter  int NREG = 8,
    localparam int AW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [2:0]    in_op,
    input  logic [AW-1:0] in_rd,
    input  logic [AW-1:0] in_rs1,
    input  logic [AW-1:0] in_rs2,
    input  logic [DW-1:0] in_imm,
    input  logic [AW-1:0] dbg_addr,
    output logic [DW-1:0] dbg_data,
    output logic          wb_valid,
    output logic [AW-1:0] wb_addr,
    output logic [DW-1:0] wb_data
);

    logic          fi_valid;
    logic [2:0]    fi_op;
    logic [AW-1:0] fi_rd;
    logic [AW-1:0] fi_rs1;
    logic [AW-1:0] fi_rs2;
    logic [DW-1:0] fi_imm;
    logic [DW-1:0] rf_a;
    logic [DW-1:0] rf_b;
    logic          ex_wr;
    logic [AW-1:0] ex_rd;
    logic [DW-1:0] ex_val;

    bp3_fetch #(
        .DW(DW),
        .AW(AW)
    ) u_fetch (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .in_op   (in_op),
        .in_rd   (in_rd),
        .in_rs1  (in_rs1),
        .in_rs2  (in_rs2),
        .in_imm  (in_imm),
        .fi_valid(fi_valid),
        .fi_op   (fi_op),
        .fi_rd   (fi_rd),
        .fi_rs1  (fi_rs1),
        .fi_rs2  (fi_rs2),
        .fi_imm  (fi_imm)
    );

    bp3_regfile #(
        .DW  (DW),
        .NREG(NREG),
        .AW  (AW)
    ) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (ex_wr),
        .wr_addr(ex_rd),
        .wr_data(ex_val),
        .ra_a   (fi_rs1),
        .ra_b   (fi_rs2),
        .ra_dbg (dbg_addr),
        .rd_a   (rf_a),
        .rd_b   (rf_b),
        .rd_dbg (dbg_data)
    );

    bp3_exec #(
        .DW(DW),
        .AW(AW)
    ) u_exec (
        .clk     (clk),
        .rst_n   (rst_n),
        .fi_valid(fi_valid),
        .fi_op   (fi_op),
        .fi_rd   (fi_rd),
        .fi_rs1  (fi_rs1),
        .fi_rs2  (fi_rs2),
        .fi_imm  (fi_imm),
        .rf_a    (rf_a),
        .rf_b    (rf_b),
        .ex_wr   (ex_wr),
        .ex_rd   (ex_rd),
        .ex_val  (ex_val)
    );

    assign wb_valid = ex_wr;
    assign wb_addr  = ex_rd;
    assign wb_data  = ex_val;

endmodule

// File: rtl/bp3_chk.sv
module bp3_chk #(
    parameter int DW = 16,
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [2:0]    in_op,
    input logic [AW-1:0] in_rd,
    input logic [AW-1:0] dbg_addr,
    input logic [DW-1:0] dbg_data,
    input logic          wb_valid,
    input logic [AW-1:0] wb_addr,
    input logic [DW-1:0] wb_data
);

    logic [1:0] live_cnt;
    logic       in_writes;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_cnt <= '0;
        end else if (live_cnt != 2'd3) begin
            live_cnt <= live_cnt + 2'd1;
        end
    end

    assign in_writes = in_valid && bp3_pkg::op_writes(in_op) && (in_rd != '0);

    // R1
    quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !wb_valid);

    // R2
    wb_follows_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt >= 2'd2 && $past(in_writes, 2)) |-> wb_valid);

    // R5
    no_spurious_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt >= 2'd2 && !$past(in_writes, 2)) |-> !wb_valid);

    // R6
    zero_dest_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_addr != '0));

    // R2
    commit_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt >= 2'd1 && $past(wb_valid) && dbg_addr == $past(wb_addr))
        |-> (dbg_data == $past(wb_data)));

endmodule

bind bypass_pipe3 bp3_chk #(
    .DW(DW),
    .AW(AW)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .in_op   (in_op),
    .in_rd   (in_rd),
    .dbg_addr(dbg_addr),
    .dbg_data(dbg_data),
    .wb_valid(wb_valid),
    .wb_addr (wb_addr),
    .wb_data (wb_data)
);

// File: tb/bypass_pipe3_tb.sv
module bypass_pipe3_tb;

    localparam int DW   = 16;
    localparam int NREG = 8;
    localparam int AW   = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [2:0]    in_op = '0;
    logic [AW-1:0] in_rd = '0;
    logic [AW-1:0] in_rs1 = '0;
    logic [AW-1:0] in_rs2 = '0;
    logic [DW-1:0] in_imm = '0;
    logic [AW-1:0] dbg_addr = '0;
    logic [DW-1:0] dbg_data;
    logic          wb_valid;
    logic [AW-1:0] wb_addr;
    logic [DW-1:0] wb_data;

    int checks = 0;
    int failures = 0;
    logic [DW-1:0] model [NREG];

    always #5 clk = ~clk;

    bypass_pipe3 #(.DW(DW), .NREG(NREG)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2), .in_imm(in_imm),
        .dbg_addr(dbg_addr), .dbg_data(dbg_data),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Drive one instruction for one cycle and advance the in-order model
    task automatic issue(input logic [2:0] op, input int rd, input int rs1,
                         input int rs2, input logic [DW-1:0] imm);
        logic [DW-1:0] r;
        @(negedge clk);
        in_valid = 1'b1;
        in_op    = op;
        in_rd    = AW'(rd);
        in_rs1   = AW'(rs1);
        in_rs2   = AW'(rs2);
        in_imm   = imm;
        case (op)
            3'd1: r = model[rs1] + model[rs2];
            3'd2: r = model[rs1] - model[rs2];
            3'd3: r = imm;
            default: r = '0;
        endcase
        if ((op == 3'd1 || op == 3'd2 || op == 3'd3) && rd != 0) model[rd] = r;
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_op    = 3'd0;
            @(posedge clk);
        end
    endtask

    task automatic compare_all(input string req);
        idle(3);
        for (int i = 0; i < NREG; i++) begin
            @(negedge clk);
            dbg_addr = AW'(i);
            #1;
            check(dbg_data == model[i], req, dbg_data, model[i]);
        end
    endtask

    // R1: reset state
    task automatic t_reset;
        for (int i = 0; i < NREG; i++) begin
            @(negedge clk);
            dbg_addr = AW'(i);
            #1;
            check(dbg_data == 16'h0, "R1 reg after reset", dbg_data, 0);
        end
        check(wb_valid == 1'b0, "R1 wb_valid in reset", wb_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(wb_valid == 1'b0, "R1 wb_valid after release", wb_valid, 0);
    endtask

    // R4 loads, R2 write-back timing
    task automatic t_load_and_timing;
        issue(3'd3, 1, 0, 0, 16'h1234);
        issue(3'd3, 2, 0, 0, 16'hFFFF);
        issue(3'd3, 3, 0, 0, 16'h0001);
        issue(3'd3, 4, 0, 0, 16'h8000);
        issue(3'd3, 6, 0, 0, 16'h7FFF);
        issue(3'd3, 7, 0, 0, 16'h0F0F);
        compare_all("R4 immediate loads");
        issue(3'd3, 5, 0, 0, 16'hABCD);
        #1;
        in_valid = 1'b0;
        in_op    = 3'd0;
        check(wb_valid == 1'b0, "R2 no wb one edge after issue", wb_valid, 0);
        @(posedge clk);
        #1;
        check(wb_valid == 1'b1, "R2 wb_valid two edges after issue", wb_valid, 1);
        check(wb_addr == 3'd5, "R2 wb_addr", wb_addr, 5);
        check(wb_data == 16'hABCD, "R2 wb_data", wb_data, 16'hABCD);
        dbg_addr = 3'd5;
        #1;
        check(dbg_data == 16'h0, "R2 not committed before edge k+3", dbg_data, 0);
        @(posedge clk);
        #1;
        check(dbg_data == 16'hABCD, "R2 committed after edge k+3", dbg_data, 16'hABCD);
    endtask

    // R2 R3 independent arithmetic with wrap-around
    task automatic t_arith;
        issue(3'd1, 1, 2, 3, 16'h0);  // FFFF + 1 wraps to 0
        issue(3'd2, 5, 3, 4, 16'h0);  // 1 - 8000
        issue(3'd2, 3, 0, 3, 16'h0);  // 0 - 1
        issue(3'd1, 6, 6, 6, 16'h0);  // 7FFF*2
        compare_all("R3 add/sub wrap");
        check(model[1] == 16'h0000 && model[5] == 16'h8001, "R3 model sanity", model[5], 16'h8001);
    endtask

    // R7 back-to-back dependencies on one and both operands
    task automatic t_bypass_chain;
        issue(3'd3, 1, 0, 0, 16'h0005);
        issue(3'd1, 2, 1, 1, 16'h0);    // both operands forwarded
        issue(3'd2, 3, 2, 1, 16'h0);    // rs1 forwarded, rs2 distance two
        issue(3'd1, 1, 7, 3, 16'h0);    // rs2 forwarded
        issue(3'd2, 4, 1, 1, 16'h0);    // both forwarded, result 0
        issue(3'd1, 4, 4, 2, 16'h0);    // self chain
        issue(3'd1, 4, 4, 4, 16'h0);
        compare_all("R7 back-to-back bypass");
    endtask

    // R8 gap of two through bubble or non-writing code
    task automatic t_gap_two;
        issue(3'd3, 6, 0, 0, 16'h0100);
        idle(1);
        issue(3'd1, 7, 6, 6, 16'h0);
        issue(3'd3, 5, 0, 0, 16'h0033);
        issue(3'd0, 5, 5, 5, 16'h0);
        issue(3'd2, 2, 5, 7, 16'h0);
        compare_all("R8 distance two via register file");
    endtask

    // R5 R9 non-writing codes do not write and are not forwarded
    task automatic t_nonwriting;
        issue(3'd3, 3, 0, 0, 16'h4444);
        idle(2);
        for (int c = 4; c < 8; c++) begin
            issue(3'(c), 3, 0, 0, 16'hDEAD);
            #1;
            in_valid = 1'b0;
            @(posedge clk);
            #1;
            check(wb_valid == 1'b0, "R5 undefined code no write-back", wb_valid, 0);
        end
        issue(3'd0, 3, 1, 2, 16'hBEEF);
        issue(3'd1, 2, 3, 3, 16'h0);     // rd field of prior none-op matches rs
        issue(3'd5, 2, 2, 2, 16'hBEEF);
        issue(3'd2, 1, 2, 0, 16'h0);
        @(negedge clk);
        in_valid = 1'b0;
        in_op    = 3'd1;
        in_rd    = 3'd3;
        in_rs1   = 3'd3;
        in_rs2   = 3'd3;
        @(posedge clk);
        compare_all("R9 no forward from non-writing stage E");
        check(model[3] == 16'h4444, "R5 r3 kept", model[3], 16'h4444);
    endtask

    // R6 register zero
    task automatic t_zero_reg;
        issue(3'd3, 0, 0, 0, 16'h5A5A);
        #1;
        in_valid = 1'b0;
        @(posedge clk);
        #1;
        check(wb_valid == 1'b0, "R6 no write-back to r0", wb_valid, 0);
        issue(3'd1, 0, 1, 2, 16'h0);
        issue(3'd1, 5, 0, 0, 16'h0);    // must not see r0 producer
        issue(3'd2, 0, 5, 1, 16'h0);
        issue(3'd2, 6, 0, 1, 16'h0);
        compare_all("R6 r0 reads zero");
    endtask

    // R10 mixed stream against the model
    task automatic t_mixed;
        for (int i = 0; i < 40; i++) begin
            int op = (i * 7 + 3) % 6;
            issue(3'(op == 5 ? 3 : op), (i * 5 + 1) % 8, (i * 3 + 2) % 8,
                  (i * 3 + 5) % 8, DW'(i * 16'h1357 + 16'h0A0B));
            if (i % 11 == 10) idle(1);
        end
        compare_all("R10 mixed in-order stream");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREG; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        t_reset();
        t_load_and_timing();
        t_arith();
        t_bypass_chain();
        t_gap_two();
        t_nonwriting();
        t_zero_reg();
        t_mixed();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule